// File: doc/BRIEF.md
# SMRAM Access Window Decoder

This block sits in the memory request path and classifies every access against three protected system-management RAM windows. A fixed compatible window lies below 1 MB. A high alias window above 1 MB reaches the same physical bytes as the compatible window. A top-of-memory segment of programmable size sits directly below the top-of-memory boundary. For each request the block returns a route and the address to use in DRAM. The route is DRAM, the legacy bus path, or blocked. A blocked read is answered with all-ones further downstream.

Each request is tagged with a management-mode flag and a code-fetch flag. Control inputs enable each window and set the segment size and the top of memory. Two override bits also act on the compatible window. The first opens it to ordinary accesses. The second steers management-mode data accesses to the legacy bus. Setting both override bits at once is an illegal setting. The block raises a configuration error flag for it and blocks every window hit while the flag is set. Results are registered and appear one clock after the request.

Top module: `smram_decoder`

## Requirements
- R1: Every request produces a response one clock later (`rsp_valid` follows `req_valid` by one cycle). After reset `rsp_valid`=0, `cfg_err`=0 and `rsp_route`=0. Route codes are 0 = DRAM, 1 = legacy bus, 2 = blocked.
- R2: With the compatible window enabled, a management-mode access in 0xA0000..0xBFFFF is routed to DRAM with its address unchanged, unless R4 applies.
- R3: A non-management access to the enabled compatible window goes to the legacy bus while the open bit is clear. It goes to DRAM, address unchanged, while the open bit is set.
- R4: While the close bit is set, a management-mode data access to the compatible window goes to the legacy bus. A management-mode code fetch to the same window still goes to DRAM.
- R5: With the high window enabled, a management-mode access in 0xFEDA0000..0xFEDBFFFF is routed to DRAM at 0xA0000 plus the offset into the window.
- R6: The top-of-memory segment spans the last N bytes below top = `cfg_tom_mb` × 1 MB. N is 128 KB, 256 KB, 512 KB or 1 MB for size codes 0, 1, 2 and 3. A management-mode access inside it goes to DRAM with its address unchanged.
- R7: A non-management access that hits the enabled top-of-memory segment or the enabled high window is routed as blocked.
- R8: `cfg_err` is set one clock after the open and close bits are both 1. Any access that hits an enabled window in that cycle is blocked, even in management mode. Accesses outside all windows keep their normal route.
- R9: An address outside every enabled window goes to DRAM when it is below top, and to the legacy bus otherwise. A disabled window's range follows this rule.
- R10: When windows overlap, the top-of-memory segment takes precedence over the high window, and the high window takes precedence over the compatible window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_smm | input | 1 | Request issued in management mode |
| req_code | input | 1 | Request is an instruction fetch |
| cfg_compat_en | input | 1 | Compatible window enable |
| cfg_high_en | input | 1 | High alias window enable |
| cfg_tseg_en | input | 1 | Top-of-memory segment enable |
| cfg_open | input | 1 | Open compatible window to ordinary accesses |
| cfg_close | input | 1 | Send management-mode data in the compatible window to the legacy bus |
| cfg_tseg_size | input | 2 | Segment size code (0..3 = 128 KB..1 MB) |
| cfg_tom_mb | input | TOM_W | Top of memory in 1 MB units |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | ADDR_W | Address to use in DRAM |
| rsp_route | output | 2 | 0 DRAM, 1 legacy bus, 2 blocked |
| cfg_err | output | 1 | Open and close were both set |

## Verification
The bench probes both ends of every window. A comparator off by one byte would block, or fail to block, the first or last byte of a window. It checks the alias remap at the last byte of the high window, where a wrong offset mask would land outside 0xBFFFF. It separates code fetches from data accesses under the close bit, which catches a design that ignores `req_code`. It sets the open and close bits together to check that management-mode hits are blocked and that accesses outside the windows are not. It also makes the top-of-memory segment overlap the compatible window. A design with the wrong window precedence would then let an ordinary access reach protected memory through the open bit.

// File: rtl/smram_pkg.sv
package smram_pkg;
    typedef enum logic [1:0] {
        ROUTE_DRAM    = 2'd0,
        ROUTE_LEGACY  = 2'd1,
        ROUTE_BLOCKED = 2'd2
    } route_e;

    // window slots, lower index wins on overlap
    localparam int WIN_TSEG   = 0;
    localparam int WIN_HIGH   = 1;
    localparam int WIN_COMPAT = 2;
    localparam int NUM_WIN    = 3;

    localparam int MB_SHIFT       = 20;
    localparam int TSEG_MIN_SHIFT = 17;
endpackage

// File: rtl/smram_range_hit.sv
module smram_range_hit #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              en,
    output logic              hit
);
    always_comb begin
        hit = en && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/smram_tseg_bounds.sv
module smram_tseg_bounds
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TOM_W  = 12
) (
    input  logic [TOM_W-1:0]  tom_mb,
    input  logic [1:0]        size_code,
    output logic [ADDR_W-1:0] tom_addr,
    output logic [ADDR_W-1:0] seg_lo,
    output logic [ADDR_W-1:0] seg_hi,
    output logic              seg_ok
);
    logic [ADDR_W-1:0] seg_bytes;

    always_comb begin
        tom_addr  = ADDR_W'(tom_mb) << MB_SHIFT;
        seg_bytes = ADDR_W'(1) << (TSEG_MIN_SHIFT + int'(size_code));
        seg_hi    = tom_addr - ADDR_W'(1);
        seg_ok    = (tom_addr != '0);
        if (tom_addr >= seg_bytes) begin
            seg_lo = tom_addr - seg_bytes;
        end else begin
            seg_lo = '0;
        end
    end
endmodule

// File: rtl/smram_route_sel.sv
module smram_route_sel
    import smram_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] ALIAS_DEST = 'h000A0000,
    parameter logic [ADDR_W-1:0] ALIAS_MASK = 'h0001FFFF
) (
    input  logic [NUM_WIN-1:0] hit,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               smm,
    input  logic               code,
    input  logic               open_bit,
    input  logic               close_bit,
    input  logic               bad_cfg,
    input  logic               below_tom,
    output route_e             route,
    output logic [ADDR_W-1:0]  addr_out
);
    always_comb begin
        route    = below_tom ? ROUTE_DRAM : ROUTE_LEGACY;
        addr_out = addr;
        if ((|hit) && bad_cfg) begin
            route = ROUTE_BLOCKED;
        end else if (hit[WIN_TSEG]) begin
            route = smm ? ROUTE_DRAM : ROUTE_BLOCKED;
        end else if (hit[WIN_HIGH]) begin
            if (smm) begin
                route    = ROUTE_DRAM;
                addr_out = ALIAS_DEST | (addr & ALIAS_MASK);
            end else begin
                route = ROUTE_BLOCKED;
            end
        end else if (hit[WIN_COMPAT]) begin
            if (smm) begin
                route = (close_bit && !code) ? ROUTE_LEGACY : ROUTE_DRAM;
            end else begin
                route = open_bit ? ROUTE_DRAM : ROUTE_LEGACY;
            end
        end
    end
endmodule

// File: rtl/smram_decoder.sv
module smram_decoder
    import smram_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                TOM_W       = 12,
    parameter logic [ADDR_W-1:0] COMPAT_BASE = 'h000A0000,
    parameter logic [ADDR_W-1:0] COMPAT_LAST = 'h000BFFFF,
    parameter logic [ADDR_W-1:0] HIGH_BASE   = 'hFEDA0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_smm,
    input  logic              req_code,
    input  logic              cfg_compat_en,
    input  logic              cfg_high_en,
    input  logic              cfg_tseg_en,
    input  logic              cfg_open,
    input  logic              cfg_close,
    input  logic [1:0]        cfg_tseg_size,
    input  logic [TOM_W-1:0]  cfg_tom_mb,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_route,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] WIN_SPAN  = COMPAT_LAST - COMPAT_BASE;
    localparam logic [ADDR_W-1:0] HIGH_LAST = HIGH_BASE + WIN_SPAN;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        route_e            route;
        logic              err;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0]  tom_addr, seg_lo, seg_hi;
    logic               seg_ok;
    logic [ADDR_W-1:0]  win_lo [NUM_WIN];
    logic [ADDR_W-1:0]  win_hi [NUM_WIN];
    logic [NUM_WIN-1:0] win_en;
    logic [NUM_WIN-1:0] win_hit;
    logic               bad_cfg;
    route_e             sel_route;
    logic [ADDR_W-1:0]  sel_addr;

    smram_tseg_bounds #(.ADDR_W(ADDR_W), .TOM_W(TOM_W)) u_bounds (
        .tom_mb    (cfg_tom_mb),
        .size_code (cfg_tseg_size),
        .tom_addr  (tom_addr),
        .seg_lo    (seg_lo),
        .seg_hi    (seg_hi),
        .seg_ok    (seg_ok)
    );

    always_comb begin
        win_lo[WIN_TSEG]   = seg_lo;
        win_hi[WIN_TSEG]   = seg_hi;
        win_en[WIN_TSEG]   = cfg_tseg_en && seg_ok;
        win_lo[WIN_HIGH]   = HIGH_BASE;
        win_hi[WIN_HIGH]   = HIGH_LAST;
        win_en[WIN_HIGH]   = cfg_high_en;
        win_lo[WIN_COMPAT] = COMPAT_BASE;
        win_hi[WIN_COMPAT] = COMPAT_LAST;
        win_en[WIN_COMPAT] = cfg_compat_en;
        bad_cfg            = cfg_open && cfg_close;
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        smram_range_hit #(.ADDR_W(ADDR_W)) u_hit (
            .addr (req_addr),
            .lo   (win_lo[g]),
            .hi   (win_hi[g]),
            .en   (win_en[g]),
            .hit  (win_hit[g])
        );
    end

    smram_route_sel #(
        .ADDR_W     (ADDR_W),
        .ALIAS_DEST (COMPAT_BASE),
        .ALIAS_MASK (WIN_SPAN)
    ) u_sel (
        .hit       (win_hit),
        .addr      (req_addr),
        .smm       (req_smm),
        .code      (req_code),
        .open_bit  (cfg_open),
        .close_bit (cfg_close),
        .bad_cfg   (bad_cfg),
        .below_tom (req_addr < tom_addr),
        .route     (sel_route),
        .addr_out  (sel_addr)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.err   = bad_cfg;
        if (req_valid) begin
            state_d.addr  = sel_addr;
            state_d.route = sel_route;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{valid: 1'b0, addr: '0, route: ROUTE_DRAM, err: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.valid;
    assign rsp_addr  = state_q.addr;
    assign rsp_route = state_q.route;
    assign cfg_err   = state_q.err;
endmodule

// File: rtl/smram_decoder_chk.sv
module smram_decoder_chk #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] COMPAT_BASE = 'h000A0000,
    parameter logic [ADDR_W-1:0] COMPAT_LAST = 'h000BFFFF,
    parameter logic [ADDR_W-1:0] HIGH_BASE   = 'hFEDA0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_smm,
    input logic              req_code,
    input logic              cfg_compat_en,
    input logic              cfg_high_en,
    input logic              cfg_tseg_en,
    input logic              cfg_open,
    input logic              cfg_close,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [1:0]        rsp_route,
    input logic              cfg_err
);
    localparam logic [ADDR_W-1:0] SPAN      = COMPAT_LAST - COMPAT_BASE;
    localparam logic [ADDR_W-1:0] HIGH_LAST = HIGH_BASE + SPAN;

    logic in_compat, in_high, both_set;
    assign in_compat = (req_addr >= COMPAT_BASE) && (req_addr <= COMPAT_LAST);
    assign in_high   = (req_addr >= HIGH_BASE) && (req_addr <= HIGH_LAST);
    assign both_set  = cfg_open && cfg_close;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_ROUTE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_route != 2'd3)); // R1

    AST_CLOSE_DATA_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_smm && !req_code && cfg_close && !cfg_open && cfg_compat_en
         && !cfg_tseg_en && in_compat) |=> (rsp_route == 2'd1)); // R4

    AST_HIGH_ALIAS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_smm && cfg_high_en && !cfg_tseg_en && !both_set && in_high)
        |=> (rsp_route == 2'd0 && rsp_addr == (COMPAT_BASE | ($past(req_addr) & SPAN)))); // R5

    AST_HIGH_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_smm && cfg_high_en && in_high) |=> (rsp_route == 2'd2)); // R7

    AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        both_set |=> cfg_err); // R8

    AST_ERR_BLOCKS_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && both_set && cfg_compat_en && in_compat) |=> (rsp_route == 2'd2)); // R8
endmodule

bind smram_decoder smram_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .COMPAT_BASE (COMPAT_BASE),
    .COMPAT_LAST (COMPAT_LAST),
    .HIGH_BASE   (HIGH_BASE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_smm       (req_smm),
    .req_code      (req_code),
    .cfg_compat_en (cfg_compat_en),
    .cfg_high_en   (cfg_high_en),
    .cfg_tseg_en   (cfg_tseg_en),
    .cfg_open      (cfg_open),
    .cfg_close     (cfg_close),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_route     (rsp_route),
    .cfg_err       (cfg_err)
);

// File: tb/smram_decoder_tb.sv
module smram_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] DRAM = 2'd0, LEG = 2'd1, BLK = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_smm = 1'b0, req_code = 1'b0;
    logic        cfg_compat_en = 1'b1, cfg_high_en = 1'b1, cfg_tseg_en = 1'b1;
    logic        cfg_open = 1'b0, cfg_close = 1'b0;
    logic [1:0]  cfg_tseg_size = 2'd0;
    logic [11:0] cfg_tom_mb = 12'd512;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_route;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_smm(req_smm), .req_code(req_code), .cfg_compat_en(cfg_compat_en),
        .cfg_high_en(cfg_high_en), .cfg_tseg_en(cfg_tseg_en), .cfg_open(cfg_open),
        .cfg_close(cfg_close), .cfg_tseg_size(cfg_tseg_size), .cfg_tom_mb(cfg_tom_mb),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_route(rsp_route), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive one request, sample the registered result one clock later
    task automatic access(input string tag, input logic [31:0] a, input logic smm,
                          input logic code, input logic [1:0] er, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_smm = smm; req_code = code;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " route"}, 32'(rsp_route), 32'(er));
        if (er != BLK) check({tag, " addr"}, rsp_addr, ea);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset err", 32'(cfg_err), 32'd0);
        check("R1 reset route", 32'(rsp_route), 32'd0);
    endtask

    task automatic t_idle;
        access("R1 one access", 32'h0010_0000, 1'b0, 1'b0, DRAM, 32'h0010_0000);
        @(negedge clk);
        check("R1 idle no valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_compat_smm;
        access("R2 smm first", 32'h000A_0000, 1'b1, 1'b0, DRAM, 32'h000A_0000);
        access("R2 smm last", 32'h000B_FFFF, 1'b1, 1'b1, DRAM, 32'h000B_FFFF);
        access("R9 below window", 32'h0009_FFFF, 1'b0, 1'b0, DRAM, 32'h0009_FFFF);
    endtask

    task automatic t_compat_open;
        access("R3 closed legacy", 32'h000A_1234, 1'b0, 1'b0, LEG, 32'h000A_1234);
        cfg_open = 1'b1;
        access("R3 open dram", 32'h000B_FFFF, 1'b0, 1'b0, DRAM, 32'h000B_FFFF);
        cfg_open = 1'b0;
    endtask

    task automatic t_close;
        cfg_close = 1'b1;
        access("R4 data legacy", 32'h000B_0000, 1'b1, 1'b0, LEG, 32'h000B_0000);
        access("R4 code dram", 32'h000B_0000, 1'b1, 1'b1, DRAM, 32'h000B_0000);
        cfg_close = 1'b0;
    endtask

    task automatic t_high;
        access("R5 alias low", 32'hFEDA_0010, 1'b1, 1'b0, DRAM, 32'h000A_0010);
        access("R5 alias last", 32'hFEDB_FFFF, 1'b1, 1'b0, DRAM, 32'h000B_FFFF);
        access("R9 above alias", 32'hFEDC_0000, 1'b1, 1'b0, LEG, 32'hFEDC_0000);
    endtask

    task automatic t_tseg;
        cfg_tseg_size = 2'd0;
        access("R6 smm seg base", 32'h1FFE_0000, 1'b1, 1'b0, DRAM, 32'h1FFE_0000);
        access("R6 below 128K seg", 32'h1FFD_FFFF, 1'b0, 1'b0, DRAM, 32'h1FFD_FFFF);
        cfg_tseg_size = 2'd3;
        access("R6 1M seg base blocked", 32'h1FF0_0000, 1'b0, 1'b0, BLK, 32'h0);
        access("R6 below 1M seg", 32'h1FEF_FFFF, 1'b0, 1'b0, DRAM, 32'h1FEF_FFFF);
        access("R9 at top legacy", 32'h2000_0000, 1'b0, 1'b0, LEG, 32'h2000_0000);
        cfg_tseg_size = 2'd0;
    endtask

    task automatic t_hidden;
        access("R7 high hidden", 32'hFEDA_0000, 1'b0, 1'b0, BLK, 32'h0);
        access("R7 seg hidden", 32'h1FFF_FFFF, 1'b0, 1'b1, BLK, 32'h0);
    endtask

    task automatic t_cfg_err;
        cfg_open = 1'b1; cfg_close = 1'b1;
        access("R8 smm compat blocked", 32'h000A_0000, 1'b1, 1'b1, BLK, 32'h0);
        check("R8 err flag", 32'(cfg_err), 32'd1);
        access("R8 smm high blocked", 32'hFEDA_0000, 1'b1, 1'b0, BLK, 32'h0);
        access("R8 outside unaffected", 32'h0010_0000, 1'b1, 1'b0, DRAM, 32'h0010_0000);
        cfg_open = 1'b0; cfg_close = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 err cleared", 32'(cfg_err), 32'd0);
    endtask

    task automatic t_disabled;
        cfg_high_en = 1'b0;
        access("R9 high disabled", 32'hFEDA_0000, 1'b0, 1'b0, LEG, 32'hFEDA_0000);
        cfg_high_en = 1'b1;
        cfg_compat_en = 1'b0;
        access("R9 compat disabled", 32'h000A_0000, 1'b0, 1'b0, DRAM, 32'h000A_0000);
        cfg_compat_en = 1'b1;
    endtask

    task automatic t_priority;
        cfg_tom_mb = 12'd1; cfg_tseg_size = 2'd3; cfg_open = 1'b1;
        access("R10 seg over compat", 32'h000A_0000, 1'b0, 1'b0, BLK, 32'h0);
        cfg_open = 1'b0; cfg_close = 1'b1;
        access("R10 seg over close", 32'h000A_0000, 1'b1, 1'b0, DRAM, 32'h000A_0000);
        cfg_close = 1'b0; cfg_tom_mb = 12'd512; cfg_tseg_size = 2'd0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_compat_smm();
        t_compat_open();
        t_close();
        t_high();
        t_tseg();
        t_hidden();
        t_cfg_err();
        t_disabled();
        t_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule